// File: doc/BRIEF.md
# Table Pointer Byte Transfer Unit

This unit moves one byte at a time between a byte-addressed program memory and an 8-bit holding latch. The memory address comes from a 21-bit pointer. A processor core loads the pointer and the latch, and reads them back, through a small register-style interface. It then starts a transfer with a one-cycle request that gives the direction (memory to latch, or latch to memory) and one of four pointer-update modes. The four modes are: keep the pointer, step it up after the access, step it down after the access, or step it up before the access.

Each transfer is handled by a three-state controller: `ST_IDLE`, `ST_ACCESS` and `ST_FINISH`. The controller has three transitions:
- *accept* (`ST_IDLE`→`ST_ACCESS`) is taken when a request is seen while idle. A pre-increment is applied on this edge.
- *strobe* (`ST_ACCESS`→`ST_FINISH`) is always taken. During `ST_ACCESS` the memory port shows the address and a one-cycle read or write strobe. Post-increment and post-decrement are applied on this edge.
- *complete* (`ST_FINISH`→`ST_IDLE`) is always taken. On this edge a read places the returned byte in the latch.

The memory port is synchronous. Read data appears on the cycle after the read strobe.

Top module: `tpa_top`

## Requirements
- R1: After reset the pointer and latch read back as 0, `busy` is low and neither memory strobe is asserted.
- R2: While idle with `req` low, `ptr_load` sets the pointer to `ptr_wdata` and `latch_load` sets the latch to `latch_wdata`; both values read back from the next cycle.
- R3: A read request (`req_write`=0) accepted while idle raises `busy` for exactly two cycles. The first busy cycle carries a single `mem_rd` pulse. The latch holds the byte returned from that address when `busy` falls.
- R4: A write request (`req_write`=1) produces a single `mem_wr` pulse in the first busy cycle, with `mem_wdata` equal to the latch. The latch is unchanged afterwards.
- R5: Mode 0 (`req_mode`=2'd0) accesses the pointer address and leaves the pointer unchanged.
- R6: Mode 1 (`req_mode`=2'd1) accesses the original pointer address and leaves the pointer one higher.
- R7: Mode 2 (`req_mode`=2'd2) accesses the original pointer address and leaves the pointer one lower.
- R8: Mode 3 (`req_mode`=2'd3) raises the pointer by one first and accesses the raised address. The pointer stays at the raised value.
- R9: All pointer steps wrap modulo 2^21: 0x1FFFFF plus one gives 0, and 0 minus one gives 0x1FFFFF.
- R10: While `busy` is high, `req`, `ptr_load` and `latch_load` are ignored. No further transfer starts, and the pointer and latch end as the first transfer alone leaves them.
- R11: When `req` is high in an idle cycle, any `ptr_load` or `latch_load` in that same cycle is dropped.
- R12: `mem_rd` and `mem_wr` are never high together. They are only ever high while `busy` is high, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Load the pointer from `ptr_wdata` |
| ptr_wdata | input | 21 | New pointer value |
| ptr_rdata | output | 21 | Current pointer value |
| latch_load | input | 1 | Load the latch from `latch_wdata` |
| latch_wdata | input | 8 | New latch value |
| latch_rdata | output | 8 | Current latch value |
| req | input | 1 | Start a transfer |
| req_write | input | 1 | 1: latch to memory, 0: memory to latch |
| req_mode | input | 2 | Pointer-update mode, 0 to 3 |
| busy | output | 1 | Transfer in progress |
| mem_addr | output | 21 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |

## Verification
The controller's state shows at the ports every cycle, so a corrupted state shows up on the next edge:
- A stuck or skipped state changes the length of `busy` or adds or drops a strobe within one cycle.
- A mode captured wrongly shows on `mem_addr` in the strobe cycle, or on `ptr_rdata` one cycle later.
- A mis-timed capture leaves a stale or wrong byte in `latch_rdata` the moment `busy` falls.

The wrap boundaries and a request or load arriving during a transfer are driven on purpose. These expose step logic that is too narrow and hand-off conditions that are too loose.

// File: rtl/tpa_pkg.sv
`timescale 1ns/1ps
package tpa_pkg;
    typedef enum logic [1:0] {
        PM_HOLD     = 2'd0,
        PM_POST_INC = 2'd1,
        PM_POST_DEC = 2'd2,
        PM_PRE_INC  = 2'd3
    } ptr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FINISH = 2'd2
    } tpa_state_e;
endpackage

// File: rtl/tpa_ctrl.sv
`timescale 1ns/1ps
module tpa_ctrl
    import tpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_write,
    input  logic [1:0] req_mode,
    output logic       ptr_up,
    output logic       ptr_down,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       latch_cap,
    output logic       busy,
    output logic       cpu_load_ok
);
    tpa_state_e state_q, state_d;
    ptr_mode_e  mode_q;
    logic       write_q;
    ptr_mode_e  req_mode_e;

    assign req_mode_e = ptr_mode_e'(req_mode);

    // state register plus captured request attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= PM_HOLD;
            write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                mode_q  <= req_mode_e;
                write_q <= req_write;
            end
        end
    end

    // transitions: accept, strobe, complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ptr_up      = 1'b0;
        ptr_down    = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        latch_cap   = 1'b0;
        busy        = 1'b1;
        cpu_load_ok = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy        = 1'b0;
                cpu_load_ok = !req;
                ptr_up      = req && (req_mode_e == PM_PRE_INC);
            end
            ST_ACCESS: begin
                mem_rd   = !write_q;
                mem_wr   = write_q;
                ptr_up   = (mode_q == PM_POST_INC);
                ptr_down = (mode_q == PM_POST_DEC);
            end
            ST_FINISH: begin
                latch_cap = !write_q;
            end
            default: busy = 1'b0;
        endcase
    end

    // R3: a busy period is exactly two cycles long
    p_busy_two_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    p_busy_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);
    // R10: loads are never granted while busy
    p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_load_ok);
endmodule

// File: rtl/tpa_ptr_reg.sv
`timescale 1ns/1ps
module tpa_ptr_reg #(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             up,
    input  logic             down,
    output logic [PTR_W-1:0] q
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (up)   q <= q + ONE;
        else if (down) q <= q - ONE;
    end

    // R11: at most one source changes the pointer in any cycle
    p_ptr_single_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, up, down}));
endmodule

// File: rtl/tpa_latch.sv
`timescale 1ns/1ps
module tpa_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (cap)  q <= cap_val;
        else if (load) q <= load_val;
    end

    // R10: processor load and memory capture never compete
    p_latch_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && cap));
endmodule

// File: rtl/tpa_top.sv
`timescale 1ns/1ps
module tpa_top #(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [PTR_W-1:0]  ptr_rdata,
    input  logic              latch_load,
    input  logic [DATA_W-1:0] latch_wdata,
    output logic [DATA_W-1:0] latch_rdata,
    input  logic              req,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    output logic              busy,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic ptr_up, ptr_down, latch_cap, cpu_load_ok;

    tpa_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_write  (req_write),
        .req_mode   (req_mode),
        .ptr_up     (ptr_up),
        .ptr_down   (ptr_down),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .latch_cap  (latch_cap),
        .busy       (busy),
        .cpu_load_ok(cpu_load_ok)
    );

    tpa_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load && cpu_load_ok),
        .load_val(ptr_wdata),
        .up      (ptr_up),
        .down    (ptr_down),
        .q       (ptr_rdata)
    );

    tpa_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (latch_load && cpu_load_ok),
        .load_val(latch_wdata),
        .cap     (latch_cap),
        .cap_val (mem_rdata),
        .q       (latch_rdata)
    );

    assign mem_addr  = ptr_rdata;
    assign mem_wdata = latch_rdata;

    // R12: strobes exclusive, inside busy, single-cycle
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_strobe_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);
    p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> (busy && !mem_rd && !mem_wr));
    // R4: a write leaves the latch untouched
    p_write_keeps_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(latch_rdata));
    // R2 / R11: idle with no request and no load keeps pointer and latch
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req && !ptr_load && !latch_load) |=>
            ($stable(ptr_rdata) && $stable(latch_rdata)));
endmodule

// File: tb/tpa_top_tb_top.sv
`timescale 1ns/1ps
module tpa_top_tb_top;
    localparam int PW = 21;
    localparam int DW = 8;
    localparam logic [PW-1:0] PMAX = {PW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_load = 1'b0;
    logic [PW-1:0] ptr_wdata = '0;
    logic [PW-1:0] ptr_rdata;
    logic          latch_load = 1'b0;
    logic [DW-1:0] latch_wdata = '0;
    logic [DW-1:0] latch_rdata;
    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic          busy;
    logic [PW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] ref_mem [256];

    int checks = 0;
    int errs   = 0;

    always #10 clk = ~clk;

    tpa_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ptr_load(ptr_load), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .latch_load(latch_load), .latch_wdata(latch_wdata), .latch_rdata(latch_rdata),
        .req(req), .req_write(req_write), .req_mode(req_mode),
        .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural memory, folded onto its low 8 address bits
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [PW-1:0] p, input int m);
        if ((m == 1 || m == 3) && p == PMAX) return "R9";
        if (m == 2 && p == '0) return "R9";
        case (m)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run_access(input logic [PW-1:0] p, input int m, input bit w,
                              input logic [DW-1:0] lv);
        logic [PW-1:0] ea, ep;
        string t;
        ea = (m == 3) ? p + PW'(1) : p;
        case (m)
            0: ep = p;
            1: ep = p + PW'(1);
            2: ep = p - PW'(1);
            default: ep = p + PW'(1);
        endcase
        t = mode_tag(p, m);
        @(negedge clk);
        ptr_load = 1'b1; ptr_wdata = p; latch_load = 1'b1; latch_wdata = lv;
        @(negedge clk);
        ptr_load = 1'b0; latch_load = 1'b0;
        chk("R2 ptr load", 32'(ptr_rdata), 32'(p));
        chk("R2 latch load", 32'(latch_rdata), 32'(lv));
        req = 1'b1; req_write = w; req_mode = 2'(m);
        @(negedge clk);
        req = 1'b0;
        chk("R3 busy access", 32'(busy), 32'd1);
        chk(w ? "R4 wr strobe" : "R3 rd strobe", 32'({mem_rd, mem_wr}), w ? 32'd1 : 32'd2);
        chk({t, " address"}, 32'(mem_addr), 32'(ea));
        if (w) chk("R4 write data", 32'(mem_wdata), 32'(lv));
        @(negedge clk);
        chk("R3 busy finish", 32'(busy), 32'd1);
        chk("R12 no second strobe", 32'({mem_rd, mem_wr}), 32'd0);
        @(negedge clk);
        chk("R3 busy low", 32'(busy), 32'd0);
        chk({t, " final ptr"}, 32'(ptr_rdata), 32'(ep));
        if (w) begin
            ref_mem[ea[7:0]] = lv;
            chk("R4 latch kept", 32'(latch_rdata), 32'(lv));
            chk("R4 memory byte", 32'(mem[ea[7:0]]), 32'(lv));
        end else begin
            chk("R3 read byte", 32'(latch_rdata), 32'(ref_mem[ea[7:0]]));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [PW-1:0] pts [6];
        pts[0] = '0; pts[1] = PW'(1); pts[2] = PMAX;
        pts[3] = PW'(21'h0ABCDE); pts[4] = PW'(21'h100000); pts[5] = PW'(21'h0000FF);
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'((i * 37 + 11) & 255);
            ref_mem[i] = 8'((i * 37 + 11) & 255);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ptr", 32'(ptr_rdata), 32'd0);
        chk("R1 latch", 32'(latch_rdata), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 strobes", 32'({mem_rd, mem_wr}), 32'd0);

        for (int pi = 0; pi < 6; pi++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 2; w++)
                    run_access(pts[pi], m, w[0], 8'(8'hA5 ^ (pi * 8 + m * 2 + w)));

        // R10: requests and loads during busy are ignored
        @(negedge clk);
        ptr_load = 1'b1; ptr_wdata = PW'(21'h40);
        @(negedge clk);
        ptr_load = 1'b0;
        req = 1'b1; req_write = 1'b0; req_mode = 2'd1;
        @(negedge clk);
        req_mode = 2'd3; req_write = 1'b1;
        ptr_load = 1'b1; ptr_wdata = PW'(21'h123);
        latch_load = 1'b1; latch_wdata = 8'hEE;
        @(negedge clk);
        @(negedge clk);
        req = 1'b0; ptr_load = 1'b0; latch_load = 1'b0;
        chk("R10 busy low", 32'(busy), 32'd0);
        chk("R10 ptr", 32'(ptr_rdata), 32'h41);
        chk("R10 latch", 32'(latch_rdata), 32'(ref_mem[8'h40]));
        @(negedge clk);
        chk("R10 no extra transfer", 32'({busy, mem_rd, mem_wr}), 32'd0);

        // R11: request wins over same-cycle loads
        ptr_load = 1'b1; ptr_wdata = PW'(21'h10);
        @(negedge clk);
        ptr_load = 1'b0;
        req = 1'b1; req_write = 1'b0; req_mode = 2'd0;
        ptr_load = 1'b1; ptr_wdata = PW'(21'h77);
        latch_load = 1'b1; latch_wdata = 8'h55;
        @(negedge clk);
        req = 1'b0; ptr_load = 1'b0; latch_load = 1'b0;
        chk("R11 address", 32'(mem_addr), 32'h10);
        @(negedge clk);
        @(negedge clk);
        chk("R11 ptr", 32'(ptr_rdata), 32'h10);
        chk("R11 latch", 32'(latch_rdata), 32'(ref_mem[8'h10]));

        finish_run();
    end
endmodule